// File: doc/BRIEF.md
# Single-Address DMA Channel

This block is one DMA channel that moves data in single-address mode. Each transfer is one memory bus cycle. Only the memory side gets an address. The external device that asked for the transfer drives the data bus or captures data from it. The channel decides which memory cycle to run, which address and function code to present, and when to hand the bus back.

Software programs five registers through a write-only port:
- a control word with an arm bit, an operand-select bit, a burst/cycle-steal bit and two size fields;
- a source address;
- a destination address;
- a function-code word holding a source code and a destination code;
- a byte count.

Once armed, the channel waits for the external request line. It then asks a simple bus master for the bus with a request/grant handshake, and runs memory cycles that each end on a cycle-done input. While a cycle is running, the channel asserts an acknowledge strobe toward the device. It also asserts a done strobe during the cycle that finishes the count. Size and address bit 0 are visible on the bus outputs, so that outside logic can steer bytes.

Top module: `sadma_channel`

## Requirements
- R1: After reset, busReq, busValid, dack, doneOut, chanActive and chanComplete are all 0.
- R2: With control bit 1 (operand select) set to 1, every cycle is a read (busRead=1). It uses the source address, the source function code (function-code register bits 2:0) and the source size (control bits 4:3).
- R3: With operand select set to 0, every cycle is a write (busRead=0). It uses the destination address, the destination function code (function-code register bits 10:8) and the destination size (control bits 6:5).
- R4: dack is high during every bus cycle. doneOut is high only during the cycle that takes the remaining count to zero.
- R5: In burst mode (control bit 2 = 1), cycles run back-to-back while dreq is held high. When dreq is low at the end of a cycle, the channel drops busReq and waits.
- R6: In cycle-steal mode (control bit 2 = 0), each rising edge of dreq produces exactly one cycle, after which busReq is released. Holding dreq high yields no further cycles.
- R7: After each cycle, the active address advances by the size in bytes. Size codes: 00 = byte (1), 01 = word (2), 10 or 11 = long word (4).
- R8: After each cycle, the byte count drops by the size. A cycle is the final one when the remaining count is no larger than the size. Arming with a count of 0 completes at once, with no bus cycle.
- R9: After the final cycle, chanComplete rises, chanActive falls and no more cycles occur. Writing the control register with bit 0 (arm) set clears chanComplete and re-arms the channel.
- R10: Register writes (select 0 = control, 1 = source, 2 = destination, 3 = function codes, 4 = count) are ignored while chanActive is 1.
- R11: busValid is asserted only after busGrant, while busReq stays high. Address and attributes hold steady until busCycleDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select |
| cfgWrData | input | REG_W | Register write data |
| dreq | input | 1 | External transfer request |
| busGrant | input | 1 | Bus granted to the channel |
| busCycleDone | input | 1 | Current memory cycle finishes this clock |
| busReq | output | 1 | Bus request |
| busValid | output | 1 | Memory cycle in progress |
| busRead | output | 1 | 1 = read cycle, 0 = write cycle |
| busAddr | output | ADDR_W | Memory address |
| busFc | output | FC_W | Function code |
| busSize | output | 2 | Operand size code |
| dack | output | 1 | Acknowledge to the requesting device |
| doneOut | output | 1 | Final-cycle strobe to the device |
| chanActive | output | 1 | Channel armed and not finished |
| chanComplete | output | 1 | Transfer finished flag |

## Verification
The bench drops dreq at the exact moment a burst cycle finishes. A channel that sampled the request late would issue one extra cycle, and that extra cycle shows up in the bus log. In cycle-steal mode it holds dreq high for a long stretch. A level-sensitive design would keep stealing cycles there, where the correct design steals only one. It programs a word-sized run with an odd count, which catches a byte counter that wraps instead of finishing. It also arms with a zero count, which would otherwise start a runaway transfer. While the channel is paused mid-transfer, the bench rewrites the address, count and control registers. A design that accepted those writes would jump addresses or end early.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_FC   = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;

  localparam int unsigned CTRL_ARM   = 0;
  localparam int unsigned CTRL_OPSEL = 1;
  localparam int unsigned CTRL_BURST = 2;
  localparam int unsigned CTRL_SSZ   = 3;
  localparam int unsigned CTRL_DSZ   = 5;
  localparam int unsigned FC_DST_LSB = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_XFER
  } chanState_e;

  typedef struct packed {
    logic advance;
    logic busy;
  } dpStrobe_t;

  function automatic logic [2:0] stepOf(input logic [1:0] sz);
    case (sz)
      2'b00:   stepOf = 3'd1;
      2'b01:   stepOf = 3'd2;
      default: stepOf = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sadma_datapath.sv
module sadma_datapath
  import sadma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned FC_W   = 3,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWrData,
  input  dpStrobe_t         strobe,
  output logic              armPulse,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [1:0]        busSize,
  output logic              busRead,
  output logic              burstMode,
  output logic              lastBeat,
  output logic              countZero
);

  logic              opSel;
  logic [1:0]        srcSize, dstSize;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [FC_W-1:0]   srcFc, dstFc;
  logic [CNT_W-1:0]  byteCnt;
  logic [2:0]        stepBytes;
  logic [ADDR_W-1:0] stepAddr;
  logic [CNT_W-1:0]  stepCnt;
  logic              writeOk;

  assign writeOk   = cfgWrEn && !strobe.busy;
  assign armPulse  = writeOk && (cfgSel == SEL_CTRL) && cfgWrData[CTRL_ARM];

  assign busRead   = opSel;
  assign busSize   = opSel ? srcSize : dstSize;
  assign busAddr   = opSel ? srcAddr : dstAddr;
  assign busFc     = opSel ? srcFc   : dstFc;

  assign stepBytes = stepOf(busSize);
  assign stepAddr  = ADDR_W'(stepBytes);
  assign stepCnt   = CNT_W'(stepBytes);
  assign lastBeat  = (byteCnt <= stepCnt);
  assign countZero = (byteCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSel     <= 1'b0;
      burstMode <= 1'b0;
      srcSize   <= 2'b00;
      dstSize   <= 2'b00;
      srcAddr   <= '0;
      dstAddr   <= '0;
      srcFc     <= '0;
      dstFc     <= '0;
      byteCnt   <= '0;
    end else if (writeOk) begin
      case (cfgSel)
        SEL_CTRL: begin
          opSel     <= cfgWrData[CTRL_OPSEL];
          burstMode <= cfgWrData[CTRL_BURST];
          srcSize   <= cfgWrData[CTRL_SSZ +: 2];
          dstSize   <= cfgWrData[CTRL_DSZ +: 2];
        end
        SEL_SRC: srcAddr <= cfgWrData[ADDR_W-1:0];
        SEL_DST: dstAddr <= cfgWrData[ADDR_W-1:0];
        SEL_FC: begin
          srcFc <= cfgWrData[FC_W-1:0];
          dstFc <= cfgWrData[FC_DST_LSB +: FC_W];
        end
        SEL_CNT: byteCnt <= cfgWrData[CNT_W-1:0];
        default: ;
      endcase
    end else if (strobe.advance) begin
      if (opSel) srcAddr <= srcAddr + stepAddr;
      else       dstAddr <= dstAddr + stepAddr;
      byteCnt <= lastBeat ? '0 : byteCnt - stepCnt;
    end
  end

endmodule

// File: rtl/sadma_control.sv
module sadma_control
  import sadma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      armPulse,
  input  logic      dreq,
  input  logic      busGrant,
  input  logic      busCycleDone,
  input  logic      burstMode,
  input  logic      lastBeat,
  input  logic      countZero,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      busValid,
  output logic      dack,
  output logic      doneOut,
  output logic      chanActive,
  output logic      chanComplete
);

  chanState_e state, stateNext;
  logic dreqPrev, stealPend, edgeNow, startReq, finishNow;

  assign edgeNow   = dreq && !dreqPrev;
  assign startReq  = burstMode ? dreq : (stealPend || edgeNow);
  assign finishNow = (state == ST_XFER) && busCycleDone && lastBeat;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (armPulse && !countZero) stateNext = ST_WAIT;
      ST_WAIT: if (startReq) stateNext = ST_ARB;
      ST_ARB:  if (busGrant) stateNext = ST_XFER;
      ST_XFER: begin
        if (busCycleDone) begin
          if (lastBeat)               stateNext = ST_IDLE;
          else if (burstMode && dreq) stateNext = busGrant ? ST_XFER : ST_ARB;
          else                        stateNext = ST_WAIT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      dreqPrev     <= 1'b0;
      stealPend    <= 1'b0;
      chanComplete <= 1'b0;
    end else begin
      state    <= stateNext;
      dreqPrev <= dreq;
      if (armPulse || state == ST_IDLE)            stealPend <= 1'b0;
      else if (state == ST_WAIT && startReq)       stealPend <= 1'b0;
      else if (edgeNow)                            stealPend <= 1'b1;
      if (armPulse)                                chanComplete <= countZero;
      else if (finishNow)                          chanComplete <= 1'b1;
    end
  end

  assign busReq         = (state == ST_ARB) || (state == ST_XFER);
  assign busValid       = (state == ST_XFER);
  assign dack           = (state == ST_XFER);
  assign doneOut        = (state == ST_XFER) && lastBeat;
  assign chanActive     = (state != ST_IDLE);
  assign strobe.busy    = (state != ST_IDLE);
  assign strobe.advance = (state == ST_XFER) && busCycleDone;

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
  import sadma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned FC_W   = 3,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              dreq,
  input  logic              busGrant,
  input  logic              busCycleDone,
  output logic              busReq,
  output logic              busValid,
  output logic              busRead,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [1:0]        busSize,
  output logic              dack,
  output logic              doneOut,
  output logic              chanActive,
  output logic              chanComplete
);

  dpStrobe_t strobe;
  logic armPulse, burstMode, lastBeat, countZero;

  sadma_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FC_W(FC_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .strobe(strobe), .armPulse(armPulse),
    .busAddr(busAddr), .busFc(busFc), .busSize(busSize), .busRead(busRead),
    .burstMode(burstMode), .lastBeat(lastBeat), .countZero(countZero)
  );

  sadma_control u_ctl (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .dreq(dreq),
    .busGrant(busGrant), .busCycleDone(busCycleDone), .burstMode(burstMode),
    .lastBeat(lastBeat), .countZero(countZero), .strobe(strobe),
    .busReq(busReq), .busValid(busValid), .dack(dack), .doneOut(doneOut),
    .chanActive(chanActive), .chanComplete(chanComplete)
  );

endmodule

// File: rtl/sadma_channel_chk.sv
module sadma_channel_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FC_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busGrant,
  input logic              busCycleDone,
  input logic              busReq,
  input logic              busValid,
  input logic              busRead,
  input logic [ADDR_W-1:0] busAddr,
  input logic [FC_W-1:0]   busFc,
  input logic [1:0]        busSize,
  input logic              dack,
  input logic              doneOut,
  input logic              chanComplete
);

  // R11
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busReq);

  // R11
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busCycleDone |=> busValid && $stable(busAddr) && $stable(busFc)
                                  && $stable(busSize) && $stable(busRead));

  // R11
  grant_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busValid) |-> $past(busGrant));

  // R4
  done_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> busValid && dack);

  // R9
  final_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut && busCycleDone |=> chanComplete && !busValid);

  // R9
  complete_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanComplete) |-> !busReq);

endmodule

bind sadma_channel sadma_channel_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
  .clk(clk), .rstN(rstN), .busGrant(busGrant), .busCycleDone(busCycleDone),
  .busReq(busReq), .busValid(busValid), .busRead(busRead), .busAddr(busAddr),
  .busFc(busFc), .busSize(busSize), .dack(dack), .doneOut(doneOut),
  .chanComplete(chanComplete)
);

// File: tb/sadma_channel_tb.sv
module sadma_channel_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        dreq = 1'b0;
  logic        busGrant = 1'b0;
  logic        busCycleDone = 1'b0;
  logic        busReq, busValid, busRead, dack, doneOut, chanActive, chanComplete;
  logic [31:0] busAddr;
  logic [2:0]  busFc;
  logic [1:0]  busSize;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [31:0] logAddr [16];
  logic [2:0]  logFc   [16];
  logic [1:0]  logSize [16];
  logic        logRead [16];
  logic        logDack [16];
  logic        logDone [16];
  int          logCnt = 0;

  always #2.5 clk = ~clk;

  sadma_channel u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .dreq(dreq), .busGrant(busGrant),
    .busCycleDone(busCycleDone), .busReq(busReq), .busValid(busValid),
    .busRead(busRead), .busAddr(busAddr), .busFc(busFc), .busSize(busSize),
    .dack(dack), .doneOut(doneOut), .chanActive(chanActive),
    .chanComplete(chanComplete)
  );

  // bus responder: grant one cycle after request, one wait state per cycle
  initial begin
    forever begin
      @(negedge clk);
      busGrant = busReq;
      if (busValid && !busCycleDone) begin
        if (logCnt < 16) begin
          logAddr[logCnt] = busAddr;
          logFc[logCnt]   = busFc;
          logSize[logCnt] = busSize;
          logRead[logCnt] = busRead;
          logDack[logCnt] = dack;
          logDone[logCnt] = doneOut;
        end
        logCnt = logCnt + 1;
        busCycleDone = 1'b1;
      end else begin
        busCycleDone = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [31:0] mkCtrl(input bit op, input bit burst,
                                         input logic [1:0] ssz, input logic [1:0] dsz);
    return 32'(1) | (32'(op) << 1) | (32'(burst) << 2) | (32'(ssz) << 3) | (32'(dsz) << 5);
  endfunction

  task automatic waitComplete();
    while (!chanComplete) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chkEq("R1", "busReq", busReq, 0);
    chkEq("R1", "busValid", busValid, 0);
    chkEq("R1", "dack", dack, 0);
    chkEq("R1", "doneOut", doneOut, 0);
    chkEq("R1", "chanActive", chanActive, 0);
    chkEq("R1", "chanComplete", chanComplete, 0);
  endtask

  // R2 R5 R7 R4: word read burst, dreq held
  task automatic testBurstRead();
    int base = logCnt;
    regWrite(3'd1, 32'h0000_1000);
    regWrite(3'd3, 32'h0000_0205);
    regWrite(3'd4, 32'd6);
    regWrite(3'd0, mkCtrl(1, 1, 2'b01, 2'b00));
    dreq = 1'b1;
    waitComplete();
    dreq = 1'b0;
    chkEq("R5", "burst beat count", logCnt - base, 3);
    for (int i = 0; i < 3; i++) begin
      chkEq("R7", "burst read addr", logAddr[base+i], 32'h1000 + 2*i);
      chkEq("R2", "read flag", logRead[base+i], 1);
      chkEq("R2", "src fc", logFc[base+i], 5);
      chkEq("R2", "src size", logSize[base+i], 1);
      chkEq("R4", "dack", logDack[base+i], 1);
      chkEq("R4", "done strobe", logDone[base+i], (i == 2));
    end
    chkEq("R9", "complete after burst", chanComplete, 1);
    chkEq("R9", "inactive after burst", chanActive, 0);
    chkEq("R5", "bus released", busReq, 0);
  endtask

  // R3 R6 R7 R9: byte write cycle steal
  task automatic testCycleSteal();
    int base = logCnt;
    regWrite(3'd2, 32'h0000_2001);
    regWrite(3'd4, 32'd3);
    regWrite(3'd0, mkCtrl(0, 0, 2'b10, 2'b00));
    chkEq("R9", "complete cleared on arm", chanComplete, 0);
    repeat (4) @(negedge clk);
    chkEq("R6", "no cycle before edge", logCnt - base, 0);
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    chkEq("R6", "one cycle per edge while held", logCnt - base, 1);
    chkEq("R6", "bus released after steal", busReq, 0);
    dreq = 1'b0;
    for (int k = 2; k <= 3; k++) begin
      repeat (3) @(negedge clk);
      dreq = 1'b1;
      wait (logCnt == base + k);
      repeat (3) @(negedge clk);
      dreq = 1'b0;
      repeat (3) @(negedge clk);
      chkEq("R6", "steal count", logCnt - base, k);
    end
    for (int i = 0; i < 3; i++) begin
      chkEq("R7", "byte write addr", logAddr[base+i], 32'h2001 + i);
      chkEq("R3", "write flag", logRead[base+i], 0);
      chkEq("R3", "dst fc", logFc[base+i], 2);
      chkEq("R3", "dst size", logSize[base+i], 0);
      chkEq("R4", "done strobe", logDone[base+i], (i == 2));
    end
    chkEq("R9", "complete after steal", chanComplete, 1);
  endtask

  // R5 R10 R7: long-word burst paused by dreq, writes during pause ignored
  task automatic testPauseAndIgnore();
    int base = logCnt;
    regWrite(3'd1, 32'h0000_0100);
    regWrite(3'd4, 32'd12);
    regWrite(3'd0, mkCtrl(1, 1, 2'b10, 2'b00));
    dreq = 1'b1;
    wait (logCnt == base + 1);
    dreq = 1'b0;
    repeat (10) @(negedge clk);
    chkEq("R5", "paused after dreq drop", logCnt - base, 1);
    chkEq("R5", "bus idle in pause", busReq, 0);
    chkEq("R10", "still active in pause", chanActive, 1);
    regWrite(3'd1, 32'hDEAD_0000);
    regWrite(3'd4, 32'd4);
    regWrite(3'd3, 32'h0000_0707);
    regWrite(3'd0, mkCtrl(0, 0, 2'b00, 2'b00));
    dreq = 1'b1;
    waitComplete();
    dreq = 1'b0;
    chkEq("R10", "beats unaffected by writes", logCnt - base, 3);
    for (int i = 0; i < 3; i++) begin
      chkEq("R10", "long addr after writes", logAddr[base+i], 32'h100 + 4*i);
      chkEq("R10", "fc kept", logFc[base+i], 5);
      chkEq("R7", "long size", logSize[base+i], 2);
      chkEq("R4", "done strobe", logDone[base+i], (i == 2));
    end
  endtask

  // R8: odd count with word size, then zero count
  task automatic testCountEdges();
    int base = logCnt;
    regWrite(3'd1, 32'h0000_0040);
    regWrite(3'd4, 32'd3);
    regWrite(3'd0, mkCtrl(1, 1, 2'b01, 2'b00));
    dreq = 1'b1;
    waitComplete();
    dreq = 1'b0;
    chkEq("R8", "odd count beats", logCnt - base, 2);
    chkEq("R8", "odd count addr1", logAddr[base+1], 32'h42);
    chkEq("R8", "odd count done", logDone[base+1], 1);
    base = logCnt;
    regWrite(3'd4, 32'd0);
    regWrite(3'd0, mkCtrl(1, 1, 2'b01, 2'b00));
    dreq = 1'b1;
    repeat (10) @(negedge clk);
    dreq = 1'b0;
    chkEq("R8", "zero count no cycle", logCnt - base, 0);
    chkEq("R8", "zero count complete", chanComplete, 1);
    chkEq("R8", "zero count idle", chanActive, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBurstRead();
    testCycleSteal();
    testPauseAndIgnore();
    testCountEdges();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule